// File: doc/BRIEF.md
# Transmit phase alignment sequencer

This controller sits in the user transmit clock domain of a serial transceiver whose transmit elastic buffer is bypassed. When a start request arrives it pulses the delay-aligner reset, waits for the matching done indication, then pulses the phase-init request and waits for phase init to complete. Completion means a rising edge on the phase-init acknowledge, and the level alone does not count. On a repeated alignment that acknowledge is already high, and it may dip low for well under one clock period before it rises again. A capture flop triggered by the falling edge of the acknowledge records such a dip, so the rise that follows is still seen.

Each wait has a programmable timeout, which allows for the slow handshakes seen at low line rates. On a timeout the sequencer pulses a full transmit reset request and runs the sequence again. The retries are bounded. When they are used up, a sticky error flag is set and the sequencer goes back to idle. The current state is visible on a debug port.

Top module: `tx_phase_align_seq`

## Requirements
- R1: While reset is asserted and directly after it, state_o reads 0 (idle), and dly_reset_o, phinit_o, tx_reset_o, aligned_o and err_o are all low.
- R2: A start_i pulse sampled in idle (0) or done (5) moves the block to state 1, where dly_reset_o is high for exactly HOLD_CYC cycles. start_i is ignored in every other state.
- R3: At most one of dly_reset_o, phinit_o and tx_reset_o is high in any cycle. phinit_o (state 3) rises only after dly_reset_done_i has been seen high in state 2, and it is then held for exactly HOLD_CYC cycles.
- R4: Phase init is complete only when phinit_done_i has been low at some point after the delay reset began and is then seen high. A phinit_done_i that stays high throughout never completes alignment.
- R5: A low pulse on phinit_done_i that is shorter than one clock period, and that falls between two sampling edges, still counts as the low event of R4.
- R6: Each of the wait states 2 and 4 ends in state 6 after exactly TIMEOUT_CYC cycles if its done condition is not met. A handshake that finishes inside the window completes normally.
- R7: State 6 drives tx_reset_o for exactly HOLD_CYC cycles. If retries remain, the sequence then restarts at state 1.
- R8: After MAX_RETRY+1 failed attempts in one alignment, err_o goes high and the block returns to idle. err_o stays high until rst_ni is asserted, including across new start pulses.
- R9: aligned_o is high exactly while the state is done (5). It falls on the cycle after an accepted start.
- R10: state_o encodes idle=0, delay reset=1, delay wait=2, phase init=3, phase wait=4, done=5, transmit reset=6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | User transmit clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request a new alignment |
| dly_reset_o | output | 1 | Delay-aligner reset request |
| dly_reset_done_i | input | 1 | Delay-aligner reset done |
| phinit_o | output | 1 | Phase-init request |
| phinit_done_i | input | 1 | Phase-init done acknowledge |
| tx_reset_o | output | 1 | Full transmit reset request |
| aligned_o | output | 1 | Alignment finished |
| err_o | output | 1 | Sticky error: retries exhausted |
| state_o | output | 3 | Debug view of the sequencer state |

## Verification
The bench builds the block with HOLD_CYC=4, TIMEOUT_CYC=64, MAX_RETRY=2 and two synchroniser stages. With these values a complete failure run (three attempts, each ending in a 64-cycle timeout) lasts only a few hundred cycles. The bench can therefore count every transmit-reset pulse, measure the exact length of each timeout window, and compare a handshake that finishes near the window's end with one that misses it. The short hold makes request widths easy to count. The acknowledge model drives a 1 ns dip inside a 5 ns clock period, which exercises the edge-capture path rather than the level sampler.

// File: rtl/txpa_pkg.sv
package txpa_pkg;
  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_DLY_RST  = 3'd1,
    ST_DLY_WAIT = 3'd2,
    ST_PH_INIT  = 3'd3,
    ST_PH_WAIT  = 3'd4,
    ST_DONE     = 3'd5,
    ST_FAIL_RST = 3'd6
  } seq_state_e;
endpackage

// File: rtl/txpa_cycle_cnt.sv
module txpa_cycle_cnt #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  output logic [WIDTH-1:0] cnt_o
);
  logic [WIDTH-1:0] cnt_q;

  // saturating up-counter, zeroed on every state change
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (restart_i)       cnt_q <= '0;
    else if (cnt_q != '1)     cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/txpa_low_catch.sv
module txpa_low_catch #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic ack_i,
  output logic seen_o
);
  logic                   clr_q;
  logic                   fall_clr_n;
  logic                   fall_q;
  logic                   lvl_q;
  logic [SYNC_STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) clr_q <= 1'b0;
    else         clr_q <= arm_i;
  end

  assign fall_clr_n = rst_ni & ~clr_q;

  // edge-triggered capture: survives a dip shorter than a clock period
  always_ff @(negedge ack_i or negedge fall_clr_n) begin
    if (!fall_clr_n) fall_q <= 1'b0;
    else             fall_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              sync_q <= '0;
    else if (arm_i || clr_q)  sync_q <= '0;
    else                      sync_q <= {sync_q[SYNC_STAGES-2:0], fall_q};
  end

  // sampled low level covers the first alignment, where ack starts low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       lvl_q <= 1'b0;
    else if (arm_i)    lvl_q <= 1'b0;
    else if (!ack_i)   lvl_q <= 1'b1;
  end

  assign seen_o = sync_q[SYNC_STAGES-1] | lvl_q;

  // R5: a recorded low event is dropped only by re-arming
  a_r5_seen_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(seen_o) |-> $past(arm_i || clr_q));
endmodule

// File: rtl/txpa_retry_ctl.sv
module txpa_retry_ctl #(
  parameter int MAX_RETRY = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic fail_i,
  output logic exhausted_o,
  output logic err_o
);
  localparam int RW = (MAX_RETRY < 1) ? 1 : $clog2(MAX_RETRY + 1);
  localparam logic [RW-1:0] R_LIMIT = RW'(MAX_RETRY);

  logic [RW-1:0] retry_q;
  logic          err_q;

  assign exhausted_o = (retry_q == R_LIMIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     retry_q <= '0;
    else if (clear_i)                retry_q <= '0;
    else if (fail_i && !exhausted_o) retry_q <= retry_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    err_q <= 1'b0;
    else if (fail_i && exhausted_o) err_q <= 1'b1;
  end

  assign err_o = err_q;

  a_r8_retry_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_q <= R_LIMIT);
  a_r8_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);
endmodule

// File: rtl/tx_phase_align_seq.sv
module tx_phase_align_seq
  import txpa_pkg::*;
#(
  parameter int HOLD_CYC    = 8,
  parameter int TIMEOUT_CYC = 65536,
  parameter int MAX_RETRY   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  output logic       dly_reset_o,
  input  logic       dly_reset_done_i,
  output logic       phinit_o,
  input  logic       phinit_done_i,
  output logic       tx_reset_o,
  output logic       aligned_o,
  output logic       err_o,
  output logic [2:0] state_o
);
  localparam int CNT_MAX = (TIMEOUT_CYC > HOLD_CYC) ? TIMEOUT_CYC : HOLD_CYC;
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_CYC - 1);
  localparam logic [CW-1:0] TO_LAST   = CW'(TIMEOUT_CYC - 1);

  seq_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q;
  logic          hold_last, to_last;
  logic          low_seen, exhausted, start_ok, fail_exit;

  txpa_cycle_cnt #(.WIDTH(CW)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (state_d != state_q),
    .cnt_o     (cnt_q)
  );

  txpa_low_catch #(.SYNC_STAGES(SYNC_STAGES)) u_low (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .arm_i  (state_q == ST_DLY_RST),
    .ack_i  (phinit_done_i),
    .seen_o (low_seen)
  );

  assign hold_last = (cnt_q == HOLD_LAST);
  assign to_last   = (cnt_q == TO_LAST);
  assign start_ok  = start_i && (state_q == ST_IDLE || state_q == ST_DONE);
  assign fail_exit = (state_q == ST_FAIL_RST) && hold_last;

  txpa_retry_ctl #(.MAX_RETRY(MAX_RETRY)) u_retry (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (start_ok),
    .fail_i      (fail_exit),
    .exhausted_o (exhausted),
    .err_o       (err_o)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (start_i) state_d = ST_DLY_RST;
      ST_DLY_RST:  if (hold_last) state_d = ST_DLY_WAIT;
      ST_DLY_WAIT: begin
        if (dly_reset_done_i) state_d = ST_PH_INIT;
        else if (to_last)     state_d = ST_FAIL_RST;
      end
      ST_PH_INIT:  if (hold_last) state_d = ST_PH_WAIT;
      ST_PH_WAIT: begin
        if (low_seen && phinit_done_i) state_d = ST_DONE;
        else if (to_last)              state_d = ST_FAIL_RST;
      end
      ST_DONE:     if (start_i) state_d = ST_DLY_RST;
      ST_FAIL_RST: if (hold_last) state_d = exhausted ? ST_IDLE : ST_DLY_RST;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign dly_reset_o = (state_q == ST_DLY_RST);
  assign phinit_o    = (state_q == ST_PH_INIT);
  assign tx_reset_o  = (state_q == ST_FAIL_RST);
  assign aligned_o   = (state_q == ST_DONE);
  assign state_o     = state_q;

  a_r2_start_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_ok |=> (dly_reset_o && !aligned_o));
  a_r9_done_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(aligned_o) |-> ($past(state_q) == ST_PH_WAIT && $past(phinit_done_i)));
  a_r6_timeout_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FAIL_RST && $past(state_q) != ST_FAIL_RST) |-> $past(cnt_q) == TO_LAST);
  a_r7_retry_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(tx_reset_o) && !err_o) |-> dly_reset_o);
  a_r3_phinit_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(phinit_o) |-> $past(dly_reset_done_i));
endmodule

// File: tb/tx_phase_align_seq_test.sv
module tx_phase_align_seq_test;
  localparam int HOLD = 4;
  localparam int TMO  = 64;
  localparam int MRT  = 2;

  localparam logic [1:0] M_RISE = 2'd0, M_GLITCH = 2'd1, M_NONE = 2'd2;

  typedef struct packed {
    logic [1:0]  mode;
    logic [15:0] lat;
    logic        init_hi;
    logic        dly_en;
    logic        exp_al;
    logic [3:0]  exp_rst;
    logic        exp_err;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{M_RISE,   16'd3,  1'b0, 1'b1, 1'b1, 4'd0, 1'b0},
    '{M_GLITCH, 16'd3,  1'b1, 1'b1, 1'b1, 4'd0, 1'b0},
    '{M_RISE,   16'd20, 1'b1, 1'b1, 1'b1, 4'd0, 1'b0},
    '{M_RISE,   16'd50, 1'b0, 1'b1, 1'b1, 4'd0, 1'b0},
    '{M_NONE,   16'd0,  1'b1, 1'b1, 1'b0, 4'd3, 1'b1},
    '{M_RISE,   16'd3,  1'b0, 1'b0, 1'b0, 4'd3, 1'b1},
    '{M_RISE,   16'd90, 1'b0, 1'b1, 1'b0, 4'd3, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic dly_done = 1'b0;
  logic ph_done = 1'b0;
  logic dly_reset, phinit, tx_reset, aligned, err;
  logic [2:0] state;

  logic [1:0]  cfg_mode = M_RISE;
  logic [15:0] cfg_lat = 16'd3;
  logic        cfg_init_hi = 1'b0;
  logic        cfg_dly_en = 1'b1;

  int checks = 0;
  int errs = 0;
  int cyc = 0;
  int n_txr_rise = 0, n_dly_hi = 0, n_ph_hi = 0, n_txr_hi = 0, n_wdly = 0, n_multi = 0;
  logic txr_prev = 1'b0;

  always #2.5 clk = ~clk;

  tx_phase_align_seq #(
    .HOLD_CYC(HOLD), .TIMEOUT_CYC(TMO), .MAX_RETRY(MRT), .SYNC_STAGES(2)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .dly_reset_o(dly_reset), .dly_reset_done_i(dly_done),
    .phinit_o(phinit), .phinit_done_i(ph_done),
    .tx_reset_o(tx_reset), .aligned_o(aligned), .err_o(err), .state_o(state)
  );

  // observers
  always @(negedge clk) begin
    cyc++;
    if (tx_reset && !txr_prev) n_txr_rise++;
    txr_prev = tx_reset;
    if (dly_reset) n_dly_hi++;
    if (phinit) n_ph_hi++;
    if (tx_reset) n_txr_hi++;
    if (state == 3'd2) n_wdly++;
    if ((int'(dly_reset) + int'(phinit) + int'(tx_reset)) > 1) n_multi++;
  end

  // transceiver acknowledge model
  logic ph_prev = 1'b0;
  logic ph_arm = 1'b0;
  int   ph_cnt = 0;
  logic d_arm = 1'b0;
  int   d_cnt = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      ph_done = cfg_init_hi; dly_done = 1'b0; ph_arm = 1'b0; d_arm = 1'b0; ph_prev = 1'b0;
    end else begin
      if (dly_reset) begin
        dly_done = 1'b0; d_arm = 1'b1; d_cnt = 0;
      end else if (d_arm && cfg_dly_en) begin
        d_cnt++;
        if (d_cnt == 2) begin dly_done = 1'b1; d_arm = 1'b0; end
      end
      if (phinit && !ph_prev) begin
        ph_cnt = 0; ph_arm = (cfg_mode != M_NONE);
        if (cfg_mode == M_RISE) ph_done = 1'b0;
      end else if (ph_arm) begin
        if (cfg_mode == M_RISE) begin
          if (!phinit) begin
            ph_cnt++;
            if (ph_cnt == int'(cfg_lat)) begin ph_done = 1'b1; ph_arm = 1'b0; end
          end
        end else begin
          ph_cnt++;
          if (ph_cnt == int'(cfg_lat)) begin
            ph_arm = 1'b0; ph_done = 1'b0; #1 ph_done = 1'b1;
          end
        end
      end
      ph_prev = phinit;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_end();
    for (int i = 0; i < 3000; i++) begin
      if (aligned || err) break;
      @(negedge clk);
    end
  endtask

  task automatic load(input vec_t v);
    cfg_mode = v.mode; cfg_lat = v.lat; cfg_init_hi = v.init_hi; cfg_dly_en = v.dly_en;
  endtask

  initial begin
    int b_rise, b_dly, b_ph, b_txr, b_wd;
    // R1 / R10: reset state
    repeat (2) @(negedge clk);
    chk("R1 state in reset", int'(state), 0);
    chk("R1 outputs in reset", int'({dly_reset, phinit, tx_reset, aligned, err}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 state after reset", int'(state), 0);
    chk("R1 outputs after reset", int'({dly_reset, phinit, tx_reset, aligned, err}), 0);

    for (int k = 0; k < NV; k++) begin
      load(VECS[k]);
      do_reset();
      b_rise = n_txr_rise; b_dly = n_dly_hi; b_ph = n_ph_hi; b_txr = n_txr_hi; b_wd = n_wdly;
      pulse_start();
      chk($sformatf("R10 state after start v%0d", k), int'(state), 1);
      wait_end();
      chk($sformatf("R4 R5 R6 aligned v%0d", k), int'(aligned), int'(VECS[k].exp_al));
      chk($sformatf("R7 tx reset pulses v%0d", k), n_txr_rise - b_rise, int'(VECS[k].exp_rst));
      chk($sformatf("R8 err v%0d", k), int'(err), int'(VECS[k].exp_err));
      chk($sformatf("R9 R10 end state v%0d", k), int'(state), VECS[k].exp_al ? 5 : 0);
      if (VECS[k].exp_al) begin
        chk($sformatf("R2 dly reset width v%0d", k), n_dly_hi - b_dly, HOLD);
        chk($sformatf("R3 phinit width v%0d", k), n_ph_hi - b_ph, HOLD);
      end else begin
        chk($sformatf("R7 tx reset width v%0d", k), n_txr_hi - b_txr, (MRT + 1) * HOLD);
      end
      if (!VECS[k].dly_en)
        chk("R6 delay wait window", n_wdly - b_wd, (MRT + 1) * TMO);
    end
    chk("R3 single request", n_multi, 0);

    // R9 / R2: restart from done, second alignment with ack already high
    load(VECS[0]);
    do_reset();
    pulse_start();
    wait_end();
    chk("R9 first aligned", int'(aligned), 1);
    chk("R4 ack left high", int'(ph_done), 1);
    pulse_start();
    chk("R9 aligned cleared on start", int'(aligned), 0);
    chk("R2 restart from done", int'(state), 1);
    wait_end();
    chk("R4 second alignment via dip", int'(aligned), 1);

    // R2: start ignored while busy
    pulse_start();
    repeat (HOLD + 1) @(negedge clk);
    chk("R2 in delay wait or later", (state >= 3'd2 && state <= 3'd4) ? 1 : 0, 1);
    b_dly = n_dly_hi;
    start = 1'b1; @(negedge clk); start = 1'b0;
    chk("R2 start ignored when busy", n_dly_hi - b_dly, 0);
    wait_end();

    // R8: err sticky across a new start
    load(VECS[4]);
    do_reset();
    pulse_start();
    wait_end();
    chk("R8 err set", int'(err), 1);
    pulse_start();
    chk("R8 err kept after start", int'(err), 1);
    chk("R8 new start accepted", int'(state), 1);
    do_reset();
    chk("R8 err cleared by reset", int'(err), 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    errs++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule